// File: doc/BRIEF.md
# Triple-Buffered Serial Sample Receiver

This block takes in a one-bit sampled intermediate-frequency stream, such as the sign or magnitude bit of a satellite-navigation radio front end. It assembles that stream into words and passes each word to a DMA engine, with no processor involvement. The bit clock and the frame-sync pulse both arrive on external pins. They are brought into the system clock domain through synchronizers. A sample is taken on one selected edge of the bit clock, and the first bit of each word is its most significant bit.

A finished word travels through three stages: the shift register, a hold (buffer) register and the data register that the DMA engine reads. One complete word can therefore wait in the hold register while the next word streams in. Each time a word lands in the data register, the block raises a one-cycle event for the DMA engine. A read strobe empties the data register.

The block keeps two sticky status flags. The overrun flag records a word that was lost because both storage stages were full. The frame-error flag records a frame sync that arrived in the middle of a word. The word length and the polarities of the bit clock and the frame sync are static configuration inputs.

Top module: `sbit_rx`

## Requirements
- R1: With `cfg_bclk_pol_i`=0, the data input is sampled on falling bit-clock edges; with 1, on rising edges. The first bit sampled is the MSB of the word.
- R2: A word starts on the sampling edge at which the frame sync is active. The frame sync is active when `fs_i` differs from `cfg_fs_pol_i` (0 = active high, 1 = active low).
- R3: A word is `cfg_len_i`+1 bits long (1 to MAX_W). It is delivered right-justified in `data_o`, with the upper bits zero.
- R4: Bits that arrive after a word is complete and before the next frame sync are ignored: they produce no event and leave `data_o` unchanged.
- R5: With no reads, two completed words are held, the oldest in the data register. After a read, the second word moves into the data register.
- R6: `evt_o` pulses for exactly one cycle each time a word enters the data register. `full_o` is then 1 until a read (`rd_i`=1 for one cycle) empties the register.
- R7: A word that completes while the hold register and the data register are both full, and no read is freeing them, is discarded. In that case `ovr_o` sets and stays set.
- R8: A frame sync that arrives before the current word is complete restarts word assembly from that bit. It also sets the sticky `fserr_o`.
- R9: A one-cycle `clr_i` clears `ovr_o` and `fserr_o`.
- R10: After reset, `data_o`=0, `full_o`=0, `evt_o`=0, `ovr_o`=0 and `fserr_o`=0.
- R11: While `full_o`=1 and no new word enters, `data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | External bit clock |
| fs_i | input | 1 | External frame sync |
| din_i | input | 1 | Serial sample bit |
| cfg_len_i | input | $clog2(MAX_W) | Word length minus one |
| cfg_bclk_pol_i | input | 1 | 0: sample on falling edge, 1: on rising edge |
| cfg_fs_pol_i | input | 1 | 0: frame sync active high, 1: active low |
| rd_i | input | 1 | DMA read strobe |
| clr_i | input | 1 | Clears the sticky status flags |
| data_o | output | MAX_W | Data register contents |
| full_o | output | 1 | Data register holds an unread word |
| evt_o | output | 1 | One-cycle receive event |
| ovr_o | output | 1 | Sticky overrun flag |
| fserr_o | output | 1 | Sticky early-frame-sync flag |

## Verification
The bench builds the block with the defaults: MAX_W=32 and two synchronizer stages. With these values the full 32-bit frame produced by a divide-by-32 sync is reachable, and so is the shortest 1-bit word. The edge case where the counter matches the last bit is covered at both extremes of `cfg_len_i`. The bit clock runs eight system cycles per period, which leaves room for the synchronizer latency inside each half period. That spacing makes the three-stage back-pressure and the discard on overrun visible to the bench.

// File: rtl/sbit_rx_pkg.sv
package sbit_rx_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/sbit_rx_sync.sv
module sbit_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st[g] <= '0;
        else if (g == 0) st[g] <= d_i;
        else st[g] <= st[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/sbit_rx_shift.sv
module sbit_rx_shift
  import sbit_rx_pkg::*;
#(
  parameter int MAX_W = 32,
  localparam int LEN_W = $clog2(MAX_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             fs_i,
  input  logic             din_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             bclk_pol_i,
  input  logic             fs_pol_i,
  output logic [MAX_W-1:0] word_o,
  output logic             done_o,
  output logic             fserr_o
);
  logic             bclk_q;
  logic             busy_q;
  logic [LEN_W-1:0] cnt_q;
  logic [MAX_W-1:0] sh_q;
  logic             smp, fs_act;

  always_comb begin
    if (edge_sel_e'(bclk_pol_i) == EDGE_RISE) smp = bclk_i & ~bclk_q;
    else                                      smp = ~bclk_i & bclk_q;
    fs_act = fs_i ^ fs_pol_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q  <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      done_o  <= 1'b0;
      fserr_o <= 1'b0;
    end else begin
      bclk_q  <= bclk_i;
      done_o  <= 1'b0;
      fserr_o <= 1'b0;
      if (smp) begin
        if (fs_act) begin
          // sync restarts assembly, even mid-word
          fserr_o <= busy_q;
          sh_q    <= {{(MAX_W-1){1'b0}}, din_i};
          if (len_i == '0) begin
            done_o <= 1'b1;
            busy_q <= 1'b0;
            cnt_q  <= '0;
          end else begin
            busy_q <= 1'b1;
            cnt_q  <= LEN_W'(1);
          end
        end else if (busy_q) begin
          sh_q <= {sh_q[MAX_W-2:0], din_i};
          if (cnt_q == len_i) begin
            done_o <= 1'b1;
            busy_q <= 1'b0;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + LEN_W'(1);
          end
        end
      end
    end
  end

  assign word_o = sh_q;
endmodule

// File: rtl/sbit_rx_handoff.sv
module sbit_rx_handoff #(
  parameter int MAX_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [MAX_W-1:0] word_i,
  input  logic             rd_i,
  output logic [MAX_W-1:0] data_o,
  output logic             full_o,
  output logic             evt_o,
  output logic             hold_full_o,
  output logic             ovr_o
);
  logic [MAX_W-1:0] hold_q;
  logic             move, accept;

  assign move   = hold_full_o & (~full_o | rd_i);
  assign accept = ~hold_full_o | move;
  assign evt_o  = move;
  assign ovr_o  = done_i & ~accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_o <= 1'b0;
      data_o      <= '0;
      full_o      <= 1'b0;
    end else begin
      if (move) begin
        data_o <= hold_q;
        full_o <= 1'b1;
      end else if (rd_i) begin
        full_o <= 1'b0;
      end
      if (done_i && accept) begin
        hold_q      <= word_i;
        hold_full_o <= 1'b1;
      end else if (move) begin
        hold_full_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sbit_rx.sv
module sbit_rx #(
  parameter int MAX_W       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(MAX_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             fs_i,
  input  logic             din_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic             cfg_bclk_pol_i,
  input  logic             cfg_fs_pol_i,
  input  logic             rd_i,
  input  logic             clr_i,
  output logic [MAX_W-1:0] data_o,
  output logic             full_o,
  output logic             evt_o,
  output logic             ovr_o,
  output logic             fserr_o
);
  logic [2:0]       pins_s;
  logic [MAX_W-1:0] word;
  logic             done, fserr_p, ovr_p, hold_full;

  sbit_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({bclk_i, fs_i, din_i}),
    .q_o (pins_s)
  );

  sbit_rx_shift #(.MAX_W(MAX_W)) u_shift (
    .clk_i, .rst_ni,
    .bclk_i     (pins_s[2]),
    .fs_i       (pins_s[1]),
    .din_i      (pins_s[0]),
    .len_i      (cfg_len_i),
    .bclk_pol_i (cfg_bclk_pol_i),
    .fs_pol_i   (cfg_fs_pol_i),
    .word_o     (word),
    .done_o     (done),
    .fserr_o    (fserr_p)
  );

  sbit_rx_handoff #(.MAX_W(MAX_W)) u_handoff (
    .clk_i, .rst_ni,
    .done_i      (done),
    .word_i      (word),
    .rd_i,
    .data_o,
    .full_o,
    .evt_o,
    .hold_full_o (hold_full),
    .ovr_o       (ovr_p)
  );

  // set beats clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_o   <= 1'b0;
      fserr_o <= 1'b0;
    end else begin
      ovr_o   <= ovr_p   | (ovr_o   & ~clr_i);
      fserr_o <= fserr_p | (fserr_o & ~clr_i);
    end
  end
endmodule

// File: rtl/sbit_rx_chk.sv
module sbit_rx_chk #(
  parameter int MAX_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_i,
  input logic             clr_i,
  input logic [MAX_W-1:0] data_o,
  input logic             full_o,
  input logic             evt_o,
  input logic             ovr_o,
  input logic             fserr_o,
  input logic             hold_full,
  input logic             done
);
  // R6: a word entering the data register leaves it full
  p_evt_fills_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> full_o);

  // R6: read with nothing waiting empties the data register
  p_rd_empties_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && rd_i && !hold_full) |=> !full_o);

  // R11: held data does not change without a new word
  p_data_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !evt_o) |=> $stable(data_o));

  // R7: overrun only when the hold stage was full on completion
  p_ovr_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> ($past(done) && $past(hold_full) && $past(full_o)));

  // R7: overrun flag is sticky
  p_ovr_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !clr_i) |=> ovr_o);

  // R8: frame-error flag is sticky
  p_fserr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fserr_o && !clr_i) |=> fserr_o);

  // R6: event is a single-cycle pulse when no read follows
  p_evt_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && !rd_i) |=> !evt_o);
endmodule

bind sbit_rx sbit_rx_chk #(.MAX_W(MAX_W)) u_chk (
  .clk_i, .rst_ni, .rd_i, .clr_i, .data_o, .full_o, .evt_o,
  .ovr_o, .fserr_o, .hold_full, .done
);

// File: tb/sbit_rx_bench.sv
module sbit_rx_bench;
  localparam int MAX_W = 32;
  localparam int LEN_W = $clog2(MAX_W);
  localparam int NV    = 7;
  // {len-1, value}
  localparam logic [LEN_W+31:0] VEC [NV] = '{
    {5'd31, 32'hA5C3_0F96},
    {5'd0,  32'h0000_0001},
    {5'd7,  32'h0000_005A},
    {5'd15, 32'h0000_8001},
    {5'd23, 32'h00C0_FFEE},
    {5'd31, 32'hFFFF_FFFF},
    {5'd31, 32'h0000_0001}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bclk = 1'b1, fs = 1'b0, din = 1'b0;
  logic [LEN_W-1:0] cfg_len = 5'd31;
  logic bpol = 1'b0, fpol = 1'b0;
  logic rd = 1'b0, clr = 1'b0;
  logic [MAX_W-1:0] data;
  logic full, evt, ovr, fserr;

  int n_chk = 0, n_fail = 0, evt_cnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sbit_rx u_sbit_rx (
    .clk_i(clk), .rst_ni, .bclk_i(bclk), .fs_i(fs), .din_i(din),
    .cfg_len_i(cfg_len), .cfg_bclk_pol_i(bpol), .cfg_fs_pol_i(fpol),
    .rd_i(rd), .clr_i(clr), .data_o(data), .full_o(full), .evt_o(evt),
    .ovr_o(ovr), .fserr_o(fserr)
  );

  always @(negedge clk) if (evt) evt_cnt++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] val, input int n, input bit with_fs);
    for (int i = n-1; i >= 0; i--) begin
      bclk = bpol ? 1'b0 : 1'b1;
      din  = val[i];
      fs   = ((i == n-1) && with_fs) ^ fpol;
      repeat (4) @(posedge clk);
      bclk = ~bclk;
      repeat (4) @(posedge clk);
    end
    bclk = bpol ? 1'b0 : 1'b1;
    fs   = fpol;
    repeat (10) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(posedge clk); #1 rd = 1'b1;
    @(posedge clk); #1 rd = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int e0;
    logic [31:0] exp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(data == 0 && !full && !evt && !ovr && !fserr, "R10 reset", {full, evt, ovr, fserr}, 0);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk);

    // vector walk: R1 R2 R3 R6
    for (int v = 0; v < NV; v++) begin
      int n;
      cfg_len = VEC[v][LEN_W+31:32];
      n   = int'(cfg_len) + 1;
      exp = (n == 32) ? VEC[v][31:0] : (VEC[v][31:0] & ((32'd1 << n) - 1));
      e0  = evt_cnt;
      send(VEC[v][31:0], n, 1'b1);
      chk(evt_cnt == e0 + 1, "R6 one event", evt_cnt - e0, 1);
      chk(data == exp, "R1/R3 word", data, exp);
      chk(full, "R6 full", full, 1);
      pulse_rd();
      chk(!full, "R6 read empties", full, 0);
    end

    // R4 trailing bits ignored
    cfg_len = 5'd7;
    send(32'h0000_003C, 8, 1'b1);
    e0 = evt_cnt;
    send(32'h0000_000F, 4, 1'b0);
    chk(evt_cnt == e0, "R4 no event", evt_cnt - e0, 0);
    chk(data == 32'h3C, "R4 data kept", data, 32'h3C);
    pulse_rd();

    // R5 R7 three-stage and overrun
    e0 = evt_cnt;
    send(32'h11, 8, 1'b1);
    send(32'h22, 8, 1'b1);
    chk(!ovr && data == 32'h11, "R5 two held", data, 32'h11);
    send(32'h33, 8, 1'b1);
    chk(ovr, "R7 overrun set", ovr, 1);
    chk(evt_cnt == e0 + 1, "R5 one event so far", evt_cnt - e0, 1);
    pulse_rd();
    chk(full && data == 32'h22, "R5 second word", data, 32'h22);
    chk(evt_cnt == e0 + 2, "R6 event on move", evt_cnt - e0, 2);
    pulse_rd();
    chk(!full && evt_cnt == e0 + 2, "R7 third discarded", evt_cnt - e0, 2);
    chk(ovr, "R7 sticky", ovr, 1);

    // R9 clear
    @(posedge clk); #1 clr = 1'b1;
    @(posedge clk); #1 clr = 1'b0;
    @(negedge clk);
    chk(!ovr, "R9 clear ovr", ovr, 0);

    // R8 early frame sync
    send(32'h15, 5, 1'b1);
    chk(!full && !fserr, "R8 partial no word", {full, fserr}, 0);
    send(32'hA7, 8, 1'b1);
    chk(fserr, "R8 fserr set", fserr, 1);
    chk(full && data == 32'hA7, "R8 restart word", data, 32'hA7);
    pulse_rd();
    @(posedge clk); #1 clr = 1'b1;
    @(posedge clk); #1 clr = 1'b0;
    @(negedge clk);
    chk(!fserr, "R9 clear fserr", fserr, 0);

    // R1 R2 inverted polarities
    bpol = 1'b1; fpol = 1'b1;
    bclk = 1'b0; fs = 1'b1;
    repeat (6) @(posedge clk);
    cfg_len = 5'd15;
    send(32'h0000_C3A5, 16, 1'b1);
    chk(full && data == 32'hC3A5, "R1/R2 rising, low sync", data, 32'hC3A5);
    chk(!fserr, "R2 no spurious error", fserr, 0);
    pulse_rd();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule